// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Each frame is a low start bit, then a configurable number of data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The character length, parity mode and stop count come from packed mode-field inputs. They are captured at the moment a byte is accepted, so a frame already in flight is not affected by later changes to those inputs.

Bytes enter through a valid/ready handshake. Bit timing comes from an external baud generator, which pulses `baudTick` for one clock cycle per bit period. An accepted byte waits for the next tick. From then on, each bit stays on the line for exactly one tick period. Control inputs gate the transmit path, abort it with a self-clearing reset, and force a break (the line held low) between a start command and a stop command. An active flag stays high for as long as a frame is committed or being shifted.

Top module: `uart_frame_tx`

## Requirements
- R1: Character length is set by `modeCharLen`: 2'b00 gives 8 data bits, 2'b10 gives 7 and 2'b11 gives 6. The code 2'b01 is treated as 8 bits. Data bits above the configured length are not sent.
- R2: Parity is set by `modeParity`. 3'b000 gives even parity, meaning the configured data bits plus the parity bit hold an even number of ones. 3'b001 gives odd parity. Every other code, including 3'b111, sends no parity bit. Parity is computed over the configured data bits only.
- R3: `modeStop` equal to 2'b10 gives two stop bits. Every other code gives one stop bit.
- R4: A byte can be accepted only while `ctlTxEnable` is 1 and `ctlTxDisable` is 0. When both are 1 the path is off, and `inReady` stays 0.
- R5: A one-cycle pulse on `ctlTxReset` aborts any frame at the next clock edge: `txActive` goes to 0 and `txLine` goes high. `txResetPending` is 1 for exactly one cycle after the pulse and then clears by itself. `inReady` is 0 while `txResetPending` is 1.
- R6: A pulse on `ctlBreakStart` drives `txLine` low from the next cycle, and the line stays low until a pulse on `ctlBreakStop`. If both pulses arrive together, the stop wins. `inReady` is 0 during a break.
- R7: `txActive` is 1 from the cycle after a byte is accepted until the tick that ends the last stop bit.
- R8: The line idles high. After acceptance the line stays high until the next `baudTick`. At that tick the start bit (0) begins, and every later tick moves to the next frame bit in the order start, data from bit 0 upward, parity, stops.
- R9: A new byte is accepted only once the tick ending the final stop bit has passed. `inReady` is 0 throughout a frame and 1 in the cycle right after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCharLen | input | 2 | Character length code |
| modeParity | input | 3 | Parity mode code |
| modeStop | input | 2 | Stop-bit count code |
| ctlTxEnable | input | 1 | Transmit enable level |
| ctlTxDisable | input | 1 | Transmit disable level, dominant over enable |
| ctlTxReset | input | 1 | Transmit path reset pulse |
| ctlBreakStart | input | 1 | Begin break pulse |
| ctlBreakStop | input | 1 | End break pulse |
| baudTick | input | 1 | One-cycle pulse per bit period |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Byte can be taken this cycle |
| txLine | output | 1 | Serial output line |
| txActive | output | 1 | A frame is committed or being shifted |
| txResetPending | output | 1 | Reset in progress, clears by itself |

## Verification
The bench walks several frame formats and captures the line once per bit. It then compares the captured bits against frames worked out by hand. This catches a design that sends data most significant bit first, that computes parity over the whole byte instead of the 7 or 6 configured bits, or that gets the number of stop bits wrong. Each of those faults changes one or more bits, or moves the point at which `txActive` falls. The directed tests cover the remaining cases. One holds `inValid` high while enable and disable are both set, to catch a design that lets enable win. One starts and stops a break, to catch a line that does not stay low across ticks or that still accepts bytes. One resets the path in the middle of a frame, to catch a design that keeps shifting or that leaves its reset flag set.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W   = 8;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + DATA_W + 1 + MAX_STOP;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  // Strobes from the control FSM to the shifting datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } txState_t;

  // Number of data bits carried for a character-length code
  function automatic int charBits(input logic [1:0] code);
    case (code)
      2'b10:   return DATA_W - 1;
      2'b11:   return DATA_W - 2;
      default: return DATA_W;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        modeCharLen,
  input  logic [2:0]        modeParity,
  input  logic [1:0]        modeStop,
  output logic              serialBit,
  output logic              lastBit
);

  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameNext;
  logic [CNT_W-1:0]   bitsLeft;
  logic [CNT_W-1:0]   frameLen;
  logic [DATA_W-1:0]  dataMask;
  int                 nBits;
  logic               hasParity;
  logic               oddParity;
  logic               twoStop;
  logic               parityBit;

  // Decode the mode fields
  always_comb begin
    nBits     = charBits(modeCharLen);
    hasParity = (modeParity == 3'b000) || (modeParity == 3'b001);
    oddParity = (modeParity == 3'b001);
    twoStop   = (modeStop == 2'b10);
  end

  // Mask off unused data bits; parity covers only the configured bits
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      dataMask[i] = (i < nBits);
    end
    parityBit = (^(inData & dataMask)) ^ oddParity;
  end

  // Assemble the frame, first bit sent at index 0, unused upper bits high
  always_comb begin
    frameNext    = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nBits) begin
        frameNext[i+1] = inData[i];
      end else if (hasParity && (i == nBits)) begin
        frameNext[i+1] = parityBit;
      end
    end
    if (hasParity && (nBits == DATA_W)) begin
      frameNext[DATA_W+1] = parityBit;
    end
  end

  always_comb begin
    frameLen = CNT_W'(1 + nBits + (hasParity ? 1 : 0) + (twoStop ? 2 : 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobe.clear) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      shiftReg <= frameNext;
      bitsLeft <= frameLen;
    end else if (strobe.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  assign serialBit = shiftReg[0];
  assign lastBit   = (bitsLeft == CNT_W'(1));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txOn,
  input  logic      resetCmd,
  input  logic      breakStartCmd,
  input  logic      breakStopCmd,
  input  logic      baudTick,
  input  logic      inValid,
  input  logic      lastBit,
  output txStrobe_t strobe,
  output logic      inReady,
  output logic      txActive,
  output logic      inShift,
  output logic      breakOn,
  output logic      resetPending
);

  txState_t state;
  txState_t stateNext;

  assign inReady  = txOn && (state == ST_IDLE) && !breakOn && !resetPending;
  assign txActive = (state != ST_IDLE);
  assign inShift  = (state == ST_SHIFT);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (resetCmd) begin
      strobe.clear = 1'b1;
      stateNext    = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (inValid && inReady) begin
            strobe.load = 1'b1;
            stateNext   = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (baudTick) stateNext = ST_SHIFT;
        end
        ST_SHIFT: begin
          if (baudTick) begin
            if (lastBit) stateNext = ST_IDLE;
            else         strobe.shift = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      resetPending <= 1'b0;
      breakOn      <= 1'b0;
    end else begin
      state        <= stateNext;
      resetPending <= resetCmd;
      if (breakStopCmd)       breakOn <= 1'b0;
      else if (breakStartCmd) breakOn <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeCharLen,
  input  logic [2:0]        modeParity,
  input  logic [1:0]        modeStop,
  input  logic              ctlTxEnable,
  input  logic              ctlTxDisable,
  input  logic              ctlTxReset,
  input  logic              ctlBreakStart,
  input  logic              ctlBreakStop,
  input  logic              baudTick,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              txLine,
  output logic              txActive,
  output logic              txResetPending
);

  txStrobe_t strobe;
  logic      txOn;
  logic      serialBit;
  logic      lastBit;
  logic      inShift;
  logic      breakOn;

  assign txOn = ctlTxEnable && !ctlTxDisable;

  uart_tx_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .txOn          (txOn),
    .resetCmd      (ctlTxReset),
    .breakStartCmd (ctlBreakStart),
    .breakStopCmd  (ctlBreakStop),
    .baudTick      (baudTick),
    .inValid       (inValid),
    .lastBit       (lastBit),
    .strobe        (strobe),
    .inReady       (inReady),
    .txActive      (txActive),
    .inShift       (inShift),
    .breakOn       (breakOn),
    .resetPending  (txResetPending)
  );

  uart_tx_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inData      (inData),
    .modeCharLen (modeCharLen),
    .modeParity  (modeParity),
    .modeStop    (modeStop),
    .serialBit   (serialBit),
    .lastBit     (lastBit)
  );

  assign txLine = breakOn ? 1'b0 : (inShift ? serialBit : 1'b1);

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic ctlTxEnable,
  input logic ctlTxDisable,
  input logic ctlTxReset,
  input logic ctlBreakStart,
  input logic ctlBreakStop,
  input logic inValid,
  input logic inReady,
  input logic txLine,
  input logic txActive,
  input logic txResetPending,
  input logic breakOn
);

  AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlTxEnable && !ctlTxDisable) |-> !inReady); // R4

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !txActive); // R9

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !ctlTxReset) |=> txActive); // R7

  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    ctlTxReset |=> (!txActive && txResetPending)); // R5

  AST_RESET_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (txResetPending && !ctlTxReset) |=> !txResetPending); // R5

  AST_BREAK_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBreakStart && !ctlBreakStop) |=> !txLine); // R6

  AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (breakOn && !ctlBreakStop) |=> !txLine); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && !breakOn) |-> txLine); // R8

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .ctlTxEnable    (ctlTxEnable),
  .ctlTxDisable   (ctlTxDisable),
  .ctlTxReset     (ctlTxReset),
  .ctlBreakStart  (ctlBreakStart),
  .ctlBreakStop   (ctlBreakStop),
  .inValid        (inValid),
  .inReady        (inReady),
  .txLine         (txLine),
  .txActive       (txActive),
  .txResetPending (txResetPending),
  .breakOn        (breakOn)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeCharLen = '0;
  logic [2:0] modeParity = 3'b111;
  logic [1:0] modeStop = '0;
  logic       ctlTxEnable = 1'b0;
  logic       ctlTxDisable = 1'b0;
  logic       ctlTxReset = 1'b0;
  logic       ctlBreakStart = 1'b0;
  logic       ctlBreakStop = 1'b0;
  logic       baudTick = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       txLine;
  logic       txActive;
  logic       txResetPending;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_frame_tx i_uart_frame_tx (
    .clk, .rstN, .modeCharLen, .modeParity, .modeStop,
    .ctlTxEnable, .ctlTxDisable, .ctlTxReset, .ctlBreakStart, .ctlBreakStop,
    .baudTick, .inData, .inValid, .inReady, .txLine, .txActive, .txResetPending
  );

  // {charLen[30:29], parity[28:26], stop[25:24], data[23:16], len[15:12], bits[11:0]}
  // bits[i] is the i-th bit on the line: start, data from bit 0, parity, stops
  localparam int NVEC = 7;
  localparam logic [30:0] VECS [NVEC] = '{
    {2'b00, 3'b111, 2'b00, 8'hA5, 4'd10, 12'h34A},  // R1 8 bits, no parity, 1 stop
    {2'b00, 3'b000, 2'b00, 8'h01, 4'd11, 12'h602},  // R2 even parity
    {2'b00, 3'b001, 2'b10, 8'h03, 4'd12, 12'hE06},  // R2 odd, R3 two stops
    {2'b10, 3'b000, 2'b00, 8'hC1, 4'd10, 12'h282},  // R1 7 bits, parity ignores bit 7
    {2'b11, 3'b001, 2'b10, 8'hFF, 4'd10, 12'h3FE},  // R1 6 bits odd, two stops
    {2'b11, 3'b111, 2'b00, 8'h2A, 4'd8,  12'h0D4},  // R1 6 bits no parity
    {2'b10, 3'b111, 2'b10, 8'h80, 4'd10, 12'h300}   // R3 7 bits, two stops
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One baud tick; returns at the falling edge after the tick was seen
  task automatic tickBit();
    repeat (2) @(negedge clk);
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
  endtask

  task automatic sendAndCheck(input logic [30:0] v, input int idx);
    int len;
    int got;
    int expMask;
    len = int'(v[15:12]);
    got = 0;
    modeCharLen = v[30:29];
    modeParity  = v[28:26];
    modeStop    = v[25:24];
    inData      = v[23:16];
    inValid     = 1'b1;
    check(inReady == 1'b1, "R9 ready before frame", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check(txActive && txLine, "R7/R8 active and high while waiting",
          int'({txActive, txLine}), 3);
    for (int i = 0; i < len; i++) begin
      tickBit();
      got = got | (int'(txLine) << i);
      if (i == 2) check(inReady == 1'b0, "R9 not ready mid-frame", int'(inReady), 0);
    end
    expMask = (1 << len) - 1;
    if ((got & expMask) != (int'(v[11:0]) & expMask))
      $display("FAIL R1/R2/R3/R8 vector %0d frame bits", idx);
    check((got & expMask) == (int'(v[11:0]) & expMask), "R1/R2/R3/R8 frame",
          got, int'(v[11:0]) & expMask);
    tickBit();
    check(!txActive && txLine && inReady, "R7/R9 frame end",
          int'({txActive, txLine, inReady}), 3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine && !txActive && !inReady && !txResetPending, "R8 reset state",
          int'({txLine, txActive, inReady, txResetPending}), 8);

    // R4: path off, an offered byte must not start a frame
    inValid = 1'b1;
    ctlTxEnable = 1'b1;
    ctlTxDisable = 1'b1;
    @(negedge clk);
    check(!inReady, "R4 disable wins over enable", int'(inReady), 0);
    tickBit();
    tickBit();
    check(!txActive && txLine, "R4 no frame while off", int'({txActive, txLine}), 1);
    inValid = 1'b0;
    ctlTxDisable = 1'b0;
    @(negedge clk);
    check(inReady, "R4 ready once enabled", int'(inReady), 1);

    for (int k = 0; k < NVEC; k++) sendAndCheck(VECS[k], k);

    // R6: break holds line low across ticks and blocks bytes
    ctlBreakStart = 1'b1;
    @(negedge clk);
    ctlBreakStart = 1'b0;
    check(!txLine && !inReady, "R6 break start", int'({txLine, inReady}), 0);
    tickBit();
    tickBit();
    check(!txLine, "R6 break held", int'(txLine), 0);
    ctlBreakStart = 1'b1;
    ctlBreakStop = 1'b1;
    @(negedge clk);
    ctlBreakStart = 1'b0;
    ctlBreakStop = 1'b0;
    check(txLine && inReady, "R6 stop wins, line released", int'({txLine, inReady}), 3);

    // R5: reset in the middle of a frame
    modeCharLen = 2'b00;
    modeParity = 3'b111;
    modeStop = 2'b00;
    inData = 8'h00;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    tickBit();
    tickBit();
    check(txActive && !txLine, "R5 frame under way", int'({txActive, txLine}), 2);
    ctlTxReset = 1'b1;
    @(negedge clk);
    ctlTxReset = 1'b0;
    check(!txActive && txLine && txResetPending && !inReady, "R5 reset aborts",
          int'({txActive, txLine, txResetPending, inReady}), 6);
    @(negedge clk);
    check(!txResetPending && inReady, "R5 reset self-clears",
          int'({txResetPending, inReady}), 1);
    tickBit();
    check(!txActive && txLine, "R5 stays idle after reset", int'({txActive, txLine}), 1);
    sendAndCheck(VECS[1], 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule